// File: doc/BRIEF.md
# Core-Storage Cycle Controller

This block lets a byte-wide nonvolatile memory stand in for magnetic core storage behind a host that runs fixed-length storage cycles. Each host cycle is a read phase followed by a complementary write phase. The controller watches three host strobes: storage in use, read phase and write phase. It also watches the host's address register and its storage buffer register. All of these are brought into the system clock domain through two-flop synchronizers. The address is captured once, when a phase is accepted, and that copy is used until the phase ends.

When a read phase starts, the controller fetches the stored word and opens the data tristate buffer. It then sets the host's buffer register with three groups of set pulses, each group a fixed number of clocks wide. The groups are the left halfword, then the right halfword, then the two generated odd-parity bits. When a write phase starts, the controller captures the buffer register and performs one memory write. Before it issues pulses or a write, it samples storage-in-use again. If that strobe has dropped, the controller abandons the phase, counts the abort and ignores the host for a whole storage cycle. After every completed phase it also ignores new strobe edges for a hold-off window that ends shortly before the complementary phase is due. This keeps one host cycle from starting two reads.

Top module: `core_cycle_ctrl`

## Requirements
- R1: While reset is high and on the first clock after it, `mem_we_o`, `data_oe_o`, `busy_o`, `set_pulse_o`, `mem_addr_o` and `abort_count_o` are all zero.
- R2: A rising read strobe with storage-in-use high produces pulses on `set_pulse_o[15:0]`. Bit b pulses exactly when stored bit b is 1, and it stays high for exactly GROUP_CLKS consecutive clocks. Bits 15:8 pulse in the first group, starting on the clock that `data_oe_o` rises. Bits 7:0 pulse in the second group, GROUP_CLKS clocks later.
- R3: The third group starts 2*GROUP_CLKS clocks after `data_oe_o` rises and carries parity. `set_pulse_o[17]` pulses when bits 15:8 hold an even number of ones. `set_pulse_o[16]` pulses when bits 7:0 hold an even number of ones. This is odd parity, and each parity pulse lasts GROUP_CLKS clocks.
- R4: A rising write strobe with storage-in-use high gives exactly one clock of `mem_we_o`. During that clock, `mem_addr_o` and `mem_wdata_o` carry the address and buffer-register value that were present when the strobe was accepted.
- R5: If storage-in-use is low when the read is about to pulse, no set pulse appears and `abort_count_o` rises by one. `busy_o` then stays high for at least CYCLE_CLKS clocks, and strobe edges during that time start nothing.
- R6: If storage-in-use is low when the write is about to happen, `mem_we_o` never rises, `abort_count_o` rises by one and the stored word is left unchanged.
- R7: After a phase completes, read or write strobe edges that arrive during the HOLD_CLKS hold-off window start no operation. An edge that arrives after the window is accepted.
- R8: `data_oe_o` is high on every clock that any set pulse is high. It falls exactly two clocks after the last parity group ends, so it is high for 3*GROUP_CLKS+2 clocks per completed read, and it is never high for a write or an aborted read.
- R9: Changing `addr_i` or `sbr_i` after a phase has been accepted does not change the address read, the address written or the data written.
- R10: `busy_o` is high from acceptance of a phase until its hold-off or abort wait ends. While `busy_o` is low, no set pulse, write enable or data enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stor_use_i | input | 1 | Host storage-in-use strobe (asynchronous) |
| rd_phase_i | input | 1 | Host read-phase strobe (asynchronous) |
| wr_phase_i | input | 1 | Host write-phase strobe (asynchronous) |
| addr_i | input | ADDR_W | Host storage address register |
| sbr_i | input | DATA_W | Host storage buffer register contents |
| mem_rdata_i | input | DATA_W | Memory read data, valid one clock after the address |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_we_o | output | 1 | Memory write enable, one clock per write |
| mem_wdata_o | output | DATA_W | Memory write data |
| data_oe_o | output | 1 | Enable for the data tristate buffer toward the host |
| set_pulse_o | output | DATA_W+2 | Buffer-register set pulses: data bits, then P2 and P1 at the top |
| busy_o | output | 1 | Phase in progress, in hold-off or in abort wait |
| abort_count_o | output | CNT_W | Number of abandoned phases, wrapping |

## Verification
The assertions assume the host holds storage-in-use, the phase strobes and the address steady long enough to cross two synchronizer flops. They also assume the memory returns read data on the clock after the address. The stimulus therefore changes every host input at least a few clocks before raising a strobe and models the memory as a one-clock synchronous array. Glitches and mid-phase address or data changes are applied only after `busy_o` shows that the phase has been accepted. This keeps each glitch inside the window that the requirement covers.

// File: rtl/core_emu_pkg.sv
package core_emu_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_CAP,
    ST_RD_PULSE,
    ST_WR_CHECK,
    ST_WR_DO,
    ST_TRI_OFF,
    ST_HOLD,
    ST_ABORT
  } cyc_state_e;

  // number of set-pulse groups per read: two halfwords plus parity
  localparam int unsigned NUM_GROUPS = 3;

endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_i;
      stable_q <= meta_q;
    end
  end

  assign sync_o = stable_q;

endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int unsigned TW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          expired_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/set_pulse_gen.sv
module set_pulse_gen #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned GROUP_CLKS = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W+1:0] pulse_o,
  output logic              done_o
);
  import core_emu_pkg::*;

  localparam int unsigned HALF = DATA_W / 2;
  localparam int unsigned PW   = DATA_W + 2;
  localparam int unsigned CW   = $clog2(GROUP_CLKS + 1);
  localparam int unsigned GW   = $clog2(NUM_GROUPS);

  logic [PW-1:0] grp_mask [NUM_GROUPS];
  logic [PW-1:0] vec_d;
  logic [PW-1:0] vec_q;
  logic [PW-1:0] pulse_q;
  logic [GW-1:0] grp_q;
  logic [CW-1:0] cnt_q;
  logic          active_q;
  logic          done_q;
  logic          par_hi;
  logic          par_lo;

  // group 0: left halfword, group 1: right halfword, group 2: parity
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar b = 0; b < PW; b++) begin : g_bit
      localparam int unsigned BG = (b >= DATA_W) ? 2 : ((b >= HALF) ? 0 : 1);
      assign grp_mask[g][b] = (BG == g);
    end
  end

  // odd parity: bit set when the halfword holds an even count of ones
  always_comb begin
    par_hi = ~(^word_i[DATA_W-1:HALF]);
    par_lo = ~(^word_i[HALF-1:0]);
    vec_d  = {par_hi, par_lo, word_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q    <= '0;
      pulse_q  <= '0;
      grp_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        vec_q    <= vec_d;
        pulse_q  <= vec_d & grp_mask[0];
        grp_q    <= '0;
        cnt_q    <= '0;
        active_q <= 1'b1;
      end else if (active_q) begin
        if (cnt_q == CW'(GROUP_CLKS - 1)) begin
          cnt_q <= '0;
          if (grp_q == GW'(NUM_GROUPS - 1)) begin
            active_q <= 1'b0;
            pulse_q  <= '0;
            done_q   <= 1'b1;
          end else begin
            grp_q   <= grp_q + GW'(1);
            pulse_q <= vec_q & grp_mask[grp_q + GW'(1)];
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign pulse_o = pulse_q;
  assign done_o  = done_q;

endmodule

// File: rtl/core_cycle_ctrl.sv
module core_cycle_ctrl #(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned GROUP_CLKS = 9,
  parameter int unsigned CYCLE_CLKS = 360,
  parameter int unsigned HOLD_CLKS  = 120,
  parameter int unsigned CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stor_use_i,
  input  logic              rd_phase_i,
  input  logic              wr_phase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] sbr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              data_oe_o,
  output logic [DATA_W+1:0] set_pulse_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  abort_count_o
);
  import core_emu_pkg::*;

  localparam int unsigned SYNC_W = 3 + ADDR_W + DATA_W;
  localparam int unsigned MAX_WAIT = (CYCLE_CLKS > HOLD_CLKS) ? CYCLE_CLKS : HOLD_CLKS;
  localparam int unsigned TW = $clog2(MAX_WAIT + 1);

  cyc_state_e        state_q;
  logic [SYNC_W-1:0] sync_bus;
  logic              stor_s, rd_s, wr_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] sbr_s;
  logic              rd_prev_q, wr_prev_q;
  logic              rd_edge, wr_edge;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q, oe_q;
  logic [CNT_W-1:0]  abort_q;
  logic              tmr_load;
  logic [TW-1:0]     tmr_val;
  logic              tmr_expired;
  logic              pulse_start;
  logic              pulse_done;

  cdc_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({stor_use_i, rd_phase_i, wr_phase_i, addr_i, sbr_i}),
    .sync_o  (sync_bus)
  );

  assign {stor_s, rd_s, wr_s, addr_s, sbr_s} = sync_bus;
  assign rd_edge = rd_s & ~rd_prev_q;
  assign wr_edge = wr_s & ~wr_prev_q;

  // pulses begin only after storage-in-use is confirmed
  assign pulse_start = (state_q == ST_RD_CAP) && stor_s;

  set_pulse_gen #(.DATA_W(DATA_W), .GROUP_CLKS(GROUP_CLKS)) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .start_i (pulse_start),
    .word_i  (mem_rdata_i),
    .pulse_o (set_pulse_o),
    .done_o  (pulse_done)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TW'(HOLD_CLKS);
    if (state_q == ST_TRI_OFF) begin
      tmr_load = 1'b1;
    end else if (((state_q == ST_RD_CAP) || (state_q == ST_WR_CHECK)) && !stor_s) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(CYCLE_CLKS);
    end
  end

  gap_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      rd_prev_q <= 1'b0;
      wr_prev_q <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      we_q      <= 1'b0;
      oe_q      <= 1'b0;
      abort_q   <= '0;
    end else begin
      rd_prev_q <= rd_s;
      wr_prev_q <= wr_s;
      case (state_q)
        ST_IDLE: begin
          if (rd_edge) begin
            addr_q  <= addr_s;
            state_q <= ST_RD_WAIT;
          end else if (wr_edge) begin
            addr_q  <= addr_s;
            wdata_q <= sbr_s;
            state_q <= ST_WR_CHECK;
          end
        end
        ST_RD_WAIT: state_q <= ST_RD_CAP;
        ST_RD_CAP: begin
          if (stor_s) begin
            oe_q    <= 1'b1;
            state_q <= ST_RD_PULSE;
          end else begin
            abort_q <= abort_q + CNT_W'(1);
            state_q <= ST_ABORT;
          end
        end
        ST_RD_PULSE: begin
          if (pulse_done) state_q <= ST_TRI_OFF;
        end
        ST_WR_CHECK: begin
          if (stor_s) begin
            we_q    <= 1'b1;
            state_q <= ST_WR_DO;
          end else begin
            abort_q <= abort_q + CNT_W'(1);
            state_q <= ST_ABORT;
          end
        end
        ST_WR_DO: begin
          we_q    <= 1'b0;
          state_q <= ST_TRI_OFF;
        end
        ST_TRI_OFF: begin
          oe_q    <= 1'b0;
          state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (tmr_expired) state_q <= ST_IDLE;
        end
        ST_ABORT: begin
          if (tmr_expired) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr_o    = addr_q;
  assign mem_we_o      = we_q;
  assign mem_wdata_o   = wdata_q;
  assign data_oe_o     = oe_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign abort_count_o = abort_q;

endmodule

// File: rtl/core_cycle_ctrl_chk.sv
module core_cycle_ctrl_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic              data_oe_o,
  input logic [DATA_W+1:0] set_pulse_o,
  input logic              busy_o,
  input logic [CNT_W-1:0]  abort_count_o
);

  AST_PULSE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
    (set_pulse_o != '0) |-> data_oe_o); // R8

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |=> !mem_we_o); // R4

  AST_WE_NOT_WITH_OE: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> !data_oe_o); // R8

  AST_ABORT_STEP: assert property (@(posedge clk) disable iff (rst)
    (abort_count_o != $past(abort_count_o)) |-> (abort_count_o == $past(abort_count_o) + CNT_W'(1))); // R5

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (abort_count_o != $past(abort_count_o)) |-> (set_pulse_o == '0 && !mem_we_o && !data_oe_o)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (set_pulse_o == '0 && !mem_we_o && !data_oe_o)); // R10

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (data_oe_o && $past(data_oe_o)) |-> $stable(mem_addr_o)); // R9

endmodule

bind core_cycle_ctrl core_cycle_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/sim_core_cycle_ctrl.sv
module sim_core_cycle_ctrl;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;
  localparam int GC     = 9;
  localparam int CYC    = 360;
  localparam int HOLD   = 120;
  localparam int CNT_W  = 8;
  localparam int PW     = DATA_W + 2;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              stor_use_i = 1'b0;
  logic              rd_phase_i = 1'b0;
  logic              wr_phase_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] sbr_i = '0;
  logic [DATA_W-1:0] mem_rdata_i;
  logic [ADDR_W-1:0] mem_addr_o;
  logic              mem_we_o;
  logic [DATA_W-1:0] mem_wdata_o;
  logic              data_oe_o;
  logic [PW-1:0]     set_pulse_o;
  logic              busy_o;
  logic [CNT_W-1:0]  abort_count_o;

  core_cycle_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GROUP_CLKS(GC),
    .CYCLE_CLKS(CYC), .HOLD_CLKS(HOLD), .CNT_W(CNT_W)
  ) u0 (
    .clk(clk), .rst(rst), .stor_use_i(stor_use_i), .rd_phase_i(rd_phase_i),
    .wr_phase_i(wr_phase_i), .addr_i(addr_i), .sbr_i(sbr_i),
    .mem_rdata_i(mem_rdata_i), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .data_oe_o(data_oe_o), .set_pulse_o(set_pulse_o),
    .busy_o(busy_o), .abort_count_o(abort_count_o)
  );

  function automatic logic [DATA_W-1:0] init_val(int i);
    return DATA_W'((i * 40503) ^ (i << 3) ^ 16'h5A3C);
  endfunction

  // odd parity per halfword, P1 (left) at bit 17, P2 (right) at bit 16
  function automatic logic [PW-1:0] exp_vec(logic [DATA_W-1:0] w);
    return {~(^w[15:8]), ~(^w[7:0]), w};
  endfunction

  function automatic int grp_of(int b);
    return (b >= DATA_W) ? 2 : ((b >= 8) ? 0 : 1);
  endfunction

  // one-clock synchronous memory model
  logic [DATA_W-1:0] mem [DEPTH];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_val(i);
    end else begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      mem_rdata_i <= mem[mem_addr_o];
    end
  end

  logic [DATA_W-1:0] exp_mem [DEPTH];

  // monitor, sampled on the falling edge
  bit mon_clr = 1'b0;
  int cyc = 0;
  int pcount [PW];
  int pfirst [PW];
  int oe_rise, oe_cycles, busy_cycles, we_cnt;
  bit oe_prev, pulse_wo_oe;
  logic [ADDR_W-1:0] we_addr;
  logic [DATA_W-1:0] we_data;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    oe_prev <= data_oe_o;
    if (mon_clr) begin
      for (int b = 0; b < PW; b++) begin pcount[b] <= 0; pfirst[b] <= -1; end
      oe_rise <= -1; oe_cycles <= 0; busy_cycles <= 0; we_cnt <= 0;
      pulse_wo_oe <= 1'b0; we_addr <= '0; we_data <= '0;
    end else begin
      for (int b = 0; b < PW; b++) begin
        if (set_pulse_o[b]) begin
          pcount[b] <= pcount[b] + 1;
          if (pcount[b] == 0) pfirst[b] <= cyc;
        end
      end
      if (data_oe_o && !oe_prev) oe_rise <= cyc;
      if (data_oe_o) oe_cycles <= oe_cycles + 1;
      if (busy_o) busy_cycles <= busy_cycles + 1;
      if (set_pulse_o != '0 && !data_oe_o) pulse_wo_oe <= 1'b1;
      if (mem_we_o) begin we_cnt <= we_cnt + 1; we_addr <= mem_addr_o; we_data <= mem_wdata_o; end
    end
  end

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_mon();
    mon_clr = 1'b1;
    @(negedge clk);
    #1 mon_clr = 1'b0;
  endtask

  task automatic wait_busy_rise();
    while (!busy_o) step(1);
  endtask

  task automatic wait_busy_fall();
    while (busy_o) step(1);
  endtask

  // mode: 0 plain, 1 hold-off glitches, 2 address change mid-phase
  task automatic run_read(logic [ADDR_W-1:0] a, bit su, int mode);
    logic [DATA_W-1:0] w;
    logic [PW-1:0] v, obs, expv;
    logic [CNT_W-1:0] ab0;
    bit cnt_ok, par_ok, ord_ok;
    w = exp_mem[a];
    v = exp_vec(w);
    expv = su ? v : '0;
    addr_i = a; stor_use_i = su;
    step(4);
    ab0 = abort_count_o;
    clear_mon();
    step(1);
    rd_phase_i = 1'b1;
    wait_busy_rise();
    if (mode == 2) addr_i = ~a;
    if (mode == 1) begin
      while (!data_oe_o) step(1);
      while (data_oe_o) step(1);
      step(3);
      rd_phase_i = 1'b0; step(3);
      rd_phase_i = 1'b1; step(3);
      wr_phase_i = 1'b1; step(4);
      wr_phase_i = 1'b0;
    end
    wait_busy_fall();
    step(6);
    if (mode == 1) chk(busy_o == 1'b0, "R7 no retrigger", 64'(busy_o), 64'd0);
    rd_phase_i = 1'b0;
    step(4);
    cnt_ok = 1'b1; par_ok = 1'b1; ord_ok = 1'b1;
    for (int b = 0; b < PW; b++) begin
      obs[b] = (pcount[b] != 0);
      if (pcount[b] != (expv[b] ? GC : 0)) begin
        if (b < DATA_W) cnt_ok = 1'b0; else par_ok = 1'b0;
      end
      if (expv[b] && pfirst[b] != oe_rise + grp_of(b) * GC) ord_ok = 1'b0;
    end
    chk(cnt_ok, su ? (mode == 2 ? "R9 data bits" : "R2 data bits") : "R5 no pulses",
        64'(obs[DATA_W-1:0]), 64'(expv[DATA_W-1:0]));
    chk(par_ok, "R3 parity bits", 64'(obs[PW-1:DATA_W]), 64'(expv[PW-1:DATA_W]));
    chk(ord_ok, "R2 group order", 64'(obs), 64'(expv));
    chk(!pulse_wo_oe && oe_cycles == (su ? 3 * GC + 2 : 0), "R8 oe window",
        64'(oe_cycles), 64'(su ? 3 * GC + 2 : 0));
    chk(we_cnt == 0, "R10 no write in read", 64'(we_cnt), 64'd0);
    if (su) begin
      chk(abort_count_o == ab0, "R2 no abort", 64'(abort_count_o), 64'(ab0));
    end else begin
      chk(abort_count_o == ab0 + CNT_W'(1), "R5 abort count", 64'(abort_count_o), 64'(ab0 + CNT_W'(1)));
      chk(busy_cycles >= CYC, "R5 abort wait", 64'(busy_cycles), 64'(CYC));
    end
  endtask

  task automatic run_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, bit su);
    logic [CNT_W-1:0] ab0;
    addr_i = a; sbr_i = d; stor_use_i = su;
    step(4);
    ab0 = abort_count_o;
    clear_mon();
    step(1);
    wr_phase_i = 1'b1;
    wait_busy_rise();
    sbr_i = ~d; addr_i = ~a;
    if (!su) begin
      step(20);
      stor_use_i = 1'b1;
      rd_phase_i = 1'b1; step(4); rd_phase_i = 1'b0;
    end
    wait_busy_fall();
    wr_phase_i = 1'b0;
    step(4);
    if (su) begin
      chk(we_cnt == 1, "R4 one write", 64'(we_cnt), 64'd1);
      chk(we_addr == a && we_data == d, "R9 write latched", {32'(we_addr), 32'(we_data)}, {32'(a), 32'(d)});
      chk(abort_count_o == ab0, "R4 no abort", 64'(abort_count_o), 64'(ab0));
      exp_mem[a] = d;
    end else begin
      chk(we_cnt == 0, "R6 write skipped", 64'(we_cnt), 64'd0);
      chk(abort_count_o == ab0 + CNT_W'(1), "R6 abort count", 64'(abort_count_o), 64'(ab0 + CNT_W'(1)));
      chk(busy_cycles >= CYC && set_pulse_o == '0, "R5 abort ignores strobes", 64'(busy_cycles), 64'(CYC));
    end
    chk(oe_cycles == 0, "R8 no oe on write", 64'(oe_cycles), 64'd0);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20260329));
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = init_val(i);
    step(3);
    chk(mem_we_o == 0 && data_oe_o == 0 && busy_o == 0 && set_pulse_o == '0 &&
        abort_count_o == '0 && mem_addr_o == '0, "R1 in reset",
        {set_pulse_o, abort_count_o, 3'(busy_o)}, 64'd0);
    @(posedge clk) #1 rst = 1'b0;
    step(1);
    chk(mem_we_o == 0 && data_oe_o == 0 && busy_o == 0 && set_pulse_o == '0 &&
        abort_count_o == '0, "R1 after reset", 64'(busy_o), 64'd0);

    run_read(10'd0, 1'b1, 0);
    run_write(10'd5, 16'h0000, 1'b1);
    run_read(10'd5, 1'b1, 0);
    run_write(10'd6, 16'h0103, 1'b1);
    run_read(10'd6, 1'b1, 0);
    run_write(10'd7, 16'hFFFF, 1'b1);
    run_read(10'd7, 1'b1, 0);
    run_read(10'd9, 1'b0, 0);
    run_write(10'd6, 16'hBEEF, 1'b0);
    run_read(10'd6, 1'b1, 0);
    run_read(10'd7, 1'b1, 1);
    run_read(10'd0, 1'b1, 0);
    run_read(10'd33, 1'b1, 2);
    run_write(10'd40, 16'h8001, 1'b1);

    for (int k = 0; k < 40; k++) begin
      logic [ADDR_W-1:0] a;
      bit su;
      a = ADDR_W'($urandom_range(0, 15));
      su = ($urandom_range(0, 99) < 85);
      if ($urandom_range(0, 1) == 1) run_write(a, DATA_W'($urandom()), su);
      else run_read(a, su, 0);
    end

    summary();
    $finish;
  end

endmodule